// File: doc/BRIEF.md
# SPI Master Channel with Register Bank

This block is one SPI master channel. It drives a serial clock, a data-out line and a chip-select pin, and it samples a data-in line. Software or a DMA engine controls it through a small word-addressed register bank. There are five registers: configuration, status, control, transmit data and receive data. The bus is a plain strobe interface. A write or read strobe is valid for one cycle. Read data is combinational from the address, and only a read of the receive register has a side effect. The bank has no back-pressure, so software or DMA paces itself with the status flags or with the two request outputs.

The configuration register selects:
- the clock polarity and phase (SPI modes 0 to 3);
- a power-of-two clock divider;
- a word length from 4 to 32 bits;
- the transfer direction: full duplex, receive only or transmit only.

A word starts when the channel is enabled and the transmit register holds data. In receive-only mode, each read of the receive register also starts the next word. The chip select follows a software force bit and nothing else.

Top module: `spi_chan`

## Requirements
- R1: Register indices are 0 config, 1 status, 2 control, 3 transmit, 4 receive. Status bit0 means a received word is waiting, bit1 means the transmit register is empty, and bit2 means the shifter is idle. Config bits outside 15:0 and 20 read as zero. After reset, status reads 3'b110, config reads 0, SCLK is low and chip select is low.
- R2: Config bit1 sets the SCLK idle level. Config bit0 selects the phase:
  - With phase 0, MISO is sampled on leading edges and MOSI changes on trailing edges.
  - With phase 1, MOSI changes on leading edges (except the first) and MISO is sampled on trailing edges.
  - Words go out MSB first, and each word has exactly 2L SCLK edges.
- R3: With divider field d (bits 5:2), every SCLK half period lasts 2^d clock cycles. The first edge comes 2^d cycles after the word loads.
- R4: The word length is L = bits 11:7 plus one, from 4 to 32; field values below 3 act as 4. Transmit words are taken from the low L bits, and received words are right-justified and zero-extended.
- R5: Mode 00 (and 11) is full duplex. Each finished word sets receive-available. A transmit write in the same cycle the shifter loads the previous word is kept, so back-to-back words go out in order.
- R6: In mode 01 (receive only), a transmit write starts the first word. Each receive read while in mode 01 starts one more word. If the mode is switched to 00 before the last read, no extra word starts.
- R7: In mode 10 (transmit only), receive-available is never set. Transmit-empty rises when the word enters the shifter, which is before the idle flag. The transfer is finished only when both flags are set.
- R8: A receive read clears receive-available. If a word finishes in the same cycle, the flag stays set and the new word is kept.
- R9: Config bit20 forces chip select active. Config bit6 gives the active level (1 means active-low). The control enable bit has no effect on chip select.
- R10: Control bit0 enables the channel. While it is 0, no word starts, and a pending word starts once it is set.
- R11: dma_tx_req is config bit14 AND transmit-empty. dma_rx_req is config bit15 AND receive-available.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 3 | Register word index |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (side effect on receive register only) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_cs | output | 1 | Chip select pin level |
| dma_tx_req | output | 1 | Transmit DMA request |
| dma_rx_req | output | 1 | Receive DMA request |

## Verification
Two pairs of functions can land in the same clock cycle.

The first pair is a receive-register read and the completion of a word. The bench provokes it by holding the receive read strobe high for the whole word and one cycle beyond. It then judges that receive-available is still set and that the register holds the new word.

The second pair is a transmit-register write and the shifter loading the previous word. The bench provokes it with two writes on consecutive cycles from idle. It then judges that the slave model captured both words in order.

// File: rtl/spi_chan_pkg.sv
`timescale 1ns/1ps
package spi_chan_pkg;
  localparam int REG_CFG  = 0;
  localparam int REG_STAT = 1;
  localparam int REG_CTRL = 2;
  localparam int REG_TXD  = 3;
  localparam int REG_RXD  = 4;

  localparam int CB_PHA   = 0;
  localparam int CB_POL   = 1;
  localparam int CB_DIV   = 2;
  localparam int CB_CSPOL = 6;
  localparam int CB_LEN   = 7;
  localparam int CB_MODE  = 12;
  localparam int CB_DMAW  = 14;
  localparam int CB_DMAR  = 15;
  localparam int CB_FORCE = 20;

  localparam logic [31:0] CFG_KEEP = 32'h0010_FFFF;

  typedef enum logic [1:0] {
    XM_DUPLEX  = 2'b00,
    XM_RX_ONLY = 2'b01,
    XM_TX_ONLY = 2'b10,
    XM_SPARE   = 2'b11
  } xfer_mode_e;
endpackage

// File: rtl/spi_chan_baud.sv
`timescale 1ns/1ps
module spi_chan_baud #(
  parameter int EXP_W = 4,
  localparam int CNT_W = 1 << EXP_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             clear,
  input  logic [EXP_W-1:0] exp_sel,
  output logic             tick
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] lim;

  always_comb lim = (CNT_W'(1) << exp_sel) - CNT_W'(1);
  assign tick = run & (cnt == lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     cnt <= '0;
    else if (clear || !run || tick) cnt <= '0;
    else                            cnt <= cnt + CNT_W'(1);
  end
endmodule

// File: rtl/spi_chan_shift.sv
`timescale 1ns/1ps
module spi_chan_shift #(
  parameter int DATA_W = 32,
  parameter int EXP_W  = 4,
  localparam int LEN_W  = $clog2(DATA_W),
  localparam int EDGE_W = LEN_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [DATA_W-1:0] tx_word,
  input  logic [LEN_W-1:0]  len_m1,
  input  logic              cpol,
  input  logic              cpha,
  input  logic [EXP_W-1:0]  div_exp,
  input  logic              miso,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rx_word,
  output logic              sclk,
  output logic              mosi
);
  logic [LEN_W-1:0]  top_idx;
  logic [EDGE_W-1:0] edge_cnt;
  logic [EDGE_W-1:0] last_edge;
  logic [DATA_W-1:0] tx_sh;
  logic [DATA_W-1:0] rx_sh;
  logic              phase;
  logic              tick;
  logic              lead;
  logic              samp_now;
  logic              shift_now;

  spi_chan_baud #(.EXP_W(EXP_W)) u_baud (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (busy),
    .clear   (start),
    .exp_sel (div_exp),
    .tick    (tick)
  );

  // shortest legal word is 4 bits; smaller fields clamp up
  always_comb top_idx   = (len_m1 < LEN_W'(3)) ? LEN_W'(3) : len_m1;
  always_comb last_edge = {top_idx, 1'b1};
  always_comb lead      = ~edge_cnt[0];
  always_comb samp_now  = tick & (lead ^ cpha);
  always_comb shift_now = tick & ~(lead ^ cpha) & (edge_cnt != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      done     <= 1'b0;
      phase    <= 1'b0;
      edge_cnt <= '0;
      tx_sh    <= '0;
      rx_sh    <= '0;
    end else begin
      done <= 1'b0;
      if (start) begin
        busy     <= 1'b1;
        phase    <= 1'b0;
        edge_cnt <= '0;
        tx_sh    <= tx_word;
        rx_sh    <= '0;
      end else if (tick) begin
        phase <= ~phase;
        if (samp_now)  rx_sh <= {rx_sh[DATA_W-2:0], miso};
        if (shift_now) tx_sh <= tx_sh << 1;
        if (edge_cnt == last_edge) begin
          busy     <= 1'b0;
          done     <= 1'b1;
          edge_cnt <= '0;
        end else begin
          edge_cnt <= edge_cnt + EDGE_W'(1);
        end
      end
    end
  end

  assign sclk    = cpol ^ phase;
  assign mosi    = tx_sh[top_idx];
  assign rx_word = rx_sh;
endmodule

// File: rtl/spi_chan.sv
`timescale 1ns/1ps
module spi_chan
  import spi_chan_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 3,
  parameter int EXP_W  = 4,
  localparam int LEN_W = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              spi_sclk,
  output logic              spi_mosi,
  input  logic              spi_miso,
  output logic              spi_cs,
  output logic              dma_tx_req,
  output logic              dma_rx_req
);
  logic [DATA_W-1:0] cfg_q;
  logic              ctrl_en;
  logic [DATA_W-1:0] tx_buf;
  logic              tx_empty;
  logic [DATA_W-1:0] rx_buf;
  logic              rx_full;
  logic              kick;
  logic              shift_busy;
  logic              shift_done;
  logic [DATA_W-1:0] shift_rx;
  logic              start;
  xfer_mode_e        mode;
  logic              wr_cfg, wr_ctrl, wr_tx, rd_rx;

  always_comb begin
    mode    = xfer_mode_e'(cfg_q[CB_MODE +: 2]);
    wr_cfg  = bus_wr & (bus_addr == ADDR_W'(REG_CFG));
    wr_ctrl = bus_wr & (bus_addr == ADDR_W'(REG_CTRL));
    wr_tx   = bus_wr & (bus_addr == ADDR_W'(REG_TXD));
    rd_rx   = bus_rd & (bus_addr == ADDR_W'(REG_RXD));
    start   = ctrl_en & ~shift_busy & (~tx_empty | kick);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q    <= '0;
      ctrl_en  <= 1'b0;
      tx_buf   <= '0;
      tx_empty <= 1'b1;
      rx_buf   <= '0;
      rx_full  <= 1'b0;
      kick     <= 1'b0;
    end else begin
      if (wr_cfg)  cfg_q   <= bus_wdata & DATA_W'(CFG_KEEP);
      if (wr_ctrl) ctrl_en <= bus_wdata[0];
      if (wr_tx)   tx_buf  <= bus_wdata;
      // a write in the load cycle refills the buffer
      if (wr_tx)      tx_empty <= 1'b0;
      else if (start) tx_empty <= 1'b1;
      if (start)                            kick <= 1'b0;
      else if (rd_rx && mode == XM_RX_ONLY) kick <= 1'b1;
      // completion beats a concurrent read
      if (shift_done && mode != XM_TX_ONLY) begin
        rx_buf  <= shift_rx;
        rx_full <= 1'b1;
      end else if (rd_rx) begin
        rx_full <= 1'b0;
      end
    end
  end

  spi_chan_shift #(.DATA_W(DATA_W), .EXP_W(EXP_W)) u_shift (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .tx_word (tx_buf),
    .len_m1  (cfg_q[CB_LEN +: LEN_W]),
    .cpol    (cfg_q[CB_POL]),
    .cpha    (cfg_q[CB_PHA]),
    .div_exp (cfg_q[CB_DIV +: EXP_W]),
    .miso    (spi_miso),
    .busy    (shift_busy),
    .done    (shift_done),
    .rx_word (shift_rx),
    .sclk    (spi_sclk),
    .mosi    (spi_mosi)
  );

  always_comb begin
    case (bus_addr)
      ADDR_W'(REG_CFG):  bus_rdata = cfg_q;
      ADDR_W'(REG_STAT): bus_rdata = {{(DATA_W-3){1'b0}}, ~shift_busy, tx_empty, rx_full};
      ADDR_W'(REG_CTRL): bus_rdata = {{(DATA_W-1){1'b0}}, ctrl_en};
      ADDR_W'(REG_TXD):  bus_rdata = tx_buf;
      ADDR_W'(REG_RXD):  bus_rdata = rx_buf;
      default:           bus_rdata = '0;
    endcase
  end

  assign spi_cs     = cfg_q[CB_CSPOL] ? ~cfg_q[CB_FORCE] : cfg_q[CB_FORCE];
  assign dma_tx_req = cfg_q[CB_DMAW] & tx_empty;
  assign dma_rx_req = cfg_q[CB_DMAR] & rx_full;
endmodule

// File: rtl/spi_chan_chk.sv
`timescale 1ns/1ps
module spi_chan_chk
  import spi_chan_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              spi_sclk,
  input logic              spi_cs,
  input logic              dma_tx_req,
  input logic [DATA_W-1:0] cfg_q,
  input logic              ctrl_en,
  input logic              shift_busy,
  input logic              shift_done,
  input logic              rx_full
);
  p_sclk_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!shift_busy && !$past(shift_busy) && $stable(cfg_q[CB_POL])) |-> $stable(spi_sclk));

  p_done_sets_rx_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_done && cfg_q[CB_MODE +: 2] != 2'b10) |=> rx_full);

  p_txonly_no_rx_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_done && cfg_q[CB_MODE +: 2] == 2'b10 && !rx_full) |=> !rx_full);

  p_read_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == ADDR_W'(REG_RXD) && !shift_done) |=> !rx_full);

  p_cs_steady_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($stable(cfg_q[CB_FORCE]) && $stable(cfg_q[CB_CSPOL])) |-> $stable(spi_cs));

  p_off_stays_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_en && !shift_busy) |=> !shift_busy);

  p_write_drops_dma_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == ADDR_W'(REG_TXD)) |=> !dma_tx_req);
endmodule

bind spi_chan spi_chan_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_wr     (bus_wr),
  .bus_rd     (bus_rd),
  .bus_addr   (bus_addr),
  .spi_sclk   (spi_sclk),
  .spi_cs     (spi_cs),
  .dma_tx_req (dma_tx_req),
  .cfg_q      (cfg_q),
  .ctrl_en    (ctrl_en),
  .shift_busy (shift_busy),
  .shift_done (shift_done),
  .rx_full    (rx_full)
);

// File: tb/spi_chan_test.sv
`timescale 1ns/1ps
module spi_chan_test;
  localparam logic [2:0] A_CFG = 3'd0, A_STAT = 3'd1, A_CTRL = 3'd2, A_TXD = 3'd3, A_RXD = 3'd4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        spi_sclk, spi_mosi, spi_miso, spi_cs, dma_tx_req, dma_rx_req;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  spi_chan uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .spi_sclk(spi_sclk), .spi_mosi(spi_mosi),
    .spi_miso(spi_miso), .spi_cs(spi_cs), .dma_tx_req(dma_tx_req), .dma_rx_req(dma_rx_req)
  );

  // slave model
  logic [31:0] slv_words [4];
  logic [31:0] cap_words [4];
  int   samp_n = 0, edge_n = 0, b_len = 8;
  logic b_pol = 1'b0, b_pha = 1'b0;
  bit   mon_on = 1'b0;
  longint first_t = 0, last_t = 0;

  always @* begin
    if ((samp_n / b_len) < 4)
      spi_miso = slv_words[samp_n / b_len][b_len - 1 - (samp_n % b_len)];
    else
      spi_miso = 1'b0;
  end

  always @(spi_sclk) begin : mon
    int w;
    if (mon_on) begin
      if (edge_n == 0) first_t = $time;
      last_t = $time;
      edge_n++;
      if ((spi_sclk != b_pol) != b_pha) begin
        w = samp_n / b_len;
        if (w < 4) cap_words[w][b_len - 1 - (samp_n % b_len)] = spi_mosi;
        samp_n++;
      end
    end
  end

  function automatic logic [31:0] mk_cfg(int pha, int pol, int dv, int csp, int ln,
                                         int md, int dw, int dr, int frc);
    return 32'(pha) | (32'(pol) << 1) | (32'(dv) << 2) | (32'(csp) << 6) |
           (32'(ln - 1) << 7) | (32'(md) << 12) | (32'(dw) << 14) |
           (32'(dr) << 15) | (32'(frc) << 20);
  endfunction

  function automatic logic [31:0] msk(int ln);
    return (ln >= 32) ? 32'hFFFF_FFFF : ((32'd1 << ln) - 32'd1);
  endfunction

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic peek(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic wait_stat(input logic [2:0] m);
    logic [31:0] s;
    int n = 0;
    do begin
      peek(A_STAT, s);
      n++;
    end while (((s[2:0] & m) != m) && n < 5000);
    if (n >= 5000) chk(s, 32'(m), "status poll timeout");
  endtask

  task automatic slv_reset(input int pol, input int pha, input int ln);
    @(negedge clk);
    b_pol = pol[0]; b_pha = pha[0]; b_len = ln;
    samp_n = 0; edge_n = 0; first_t = 0; last_t = 0;
    for (int i = 0; i < 4; i++) cap_words[i] = '0;
    mon_on = 1'b1;
  endtask

  task automatic xfer_fd(input int pha, input int pol, input int dv, input int ln,
                         input logic [31:0] txw, input logic [31:0] sv);
    logic [31:0] got;
    wr(A_CFG, mk_cfg(pha, pol, dv, 1, ln, 0, 0, 0, 0));
    slv_reset(pol, pha, ln);
    slv_words[0] = sv;
    wr(A_TXD, txw);
    wait_stat(3'b101);
    rd(A_RXD, got);
    chk(got, sv & msk(ln), "R4 received word right-justified");
    chk(cap_words[0], txw & msk(ln), "R2 MOSI bits MSB first");
    chk(32'(edge_n), 32'(2 * ln), "R2 edge count");
    chk(32'(spi_sclk), 32'(pol), "R2 idle level");
    chk(32'(last_t - first_t), 32'((2 * ln - 1) * (1 << dv) * 8), "R3 edge spacing");
  endtask

  initial begin
    #(200000 * 8);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] r, s;
    int lens [5] = '{4, 5, 8, 13, 32};
    int it = 0;
    bit saw_gap;
    for (int i = 0; i < 4; i++) slv_words[i] = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state and register map
    peek(A_STAT, r); chk(r, 32'h6, "R1 reset status");
    peek(A_CFG, r);  chk(r, 32'h0, "R1 reset config");
    peek(A_RXD, r);  chk(r, 32'h0, "R1 reset receive");
    chk(32'(spi_sclk), 0, "R1 reset sclk");
    chk(32'(spi_cs), 0, "R1 reset cs");
    chk(32'({dma_tx_req, dma_rx_req}), 0, "R1 reset dma");
    wr(A_CFG, 32'hFFFF_FFFF);
    peek(A_CFG, r); chk(r, 32'h0010_FFFF, "R1 config readback mask");
    wr(A_CFG, 32'h0);

    // R9 chip select, enable left off
    wr(A_CFG, mk_cfg(0, 0, 0, 1, 8, 0, 0, 0, 0)); @(negedge clk);
    chk(32'(spi_cs), 1, "R9 active-low released");
    wr(A_CFG, mk_cfg(0, 0, 0, 1, 8, 0, 0, 0, 1)); @(negedge clk);
    chk(32'(spi_cs), 0, "R9 active-low forced");
    wr(A_CFG, mk_cfg(0, 0, 0, 0, 8, 0, 0, 0, 1)); @(negedge clk);
    chk(32'(spi_cs), 1, "R9 active-high forced");
    wr(A_CTRL, 32'h1); @(negedge clk);
    chk(32'(spi_cs), 1, "R9 enable does not move cs");
    wr(A_CFG, mk_cfg(0, 0, 0, 0, 8, 0, 0, 0, 0)); @(negedge clk);
    chk(32'(spi_cs), 0, "R9 active-high released");
    wr(A_CTRL, 32'h0);

    // R10 enable gating
    wr(A_CFG, mk_cfg(0, 0, 0, 1, 6, 0, 0, 0, 0));
    slv_reset(0, 0, 6);
    slv_words[0] = 32'h2D;
    wr(A_TXD, 32'h15);
    repeat (30) @(negedge clk);
    chk(32'(edge_n), 0, "R10 no edges while disabled");
    peek(A_STAT, r); chk(32'(r[1]), 0, "R10 word held while disabled");
    wr(A_CTRL, 32'h1);
    wait_stat(3'b101);
    chk(32'(edge_n), 12, "R10 pending word runs after enable");
    rd(A_RXD, r); chk(r, 32'h2D, "R10 data after enable");

    // R2 R3 R4 sweep over modes, lengths, dividers
    for (int m = 0; m < 4; m++)
      for (int li = 0; li < 5; li++)
        for (int dv = 0; dv < 2; dv++) begin
          logic [31:0] t, v;
          t = 32'hA5C3_96E1 ^ (32'(it) * 32'h1F3D_5B79);
          v = {t[15:0], ~t[31:16]} ^ 32'h3C3C_0F0F;
          xfer_fd(m & 1, m >> 1, dv, lens[li], t, v);
          it++;
        end

    // R3 larger dividers
    for (int dv = 2; dv < 5; dv++) xfer_fd(1, 0, dv, 4, 32'h9, 32'h6);

    // R4 short length field clamps to 4
    wr(A_CFG, mk_cfg(0, 0, 0, 1, 2, 0, 0, 0, 0));
    slv_reset(0, 0, 4);
    slv_words[0] = 32'hB;
    wr(A_TXD, 32'hFFFF_FFF6);
    wait_stat(3'b101);
    rd(A_RXD, r);
    chk(32'(edge_n), 8, "R4 clamp edge count");
    chk(r, 32'hB, "R4 clamp received");
    chk(cap_words[0], 32'h6, "R4 clamp sent");

    // R5 back-to-back writes, second coincides with the load
    wr(A_CFG, mk_cfg(0, 0, 0, 1, 8, 0, 0, 0, 0));
    slv_reset(0, 0, 8);
    slv_words[0] = 32'h11; slv_words[1] = 32'hE7;
    @(negedge clk);
    bus_addr = A_TXD; bus_wdata = 32'hC4; bus_wr = 1'b1;
    @(negedge clk);
    bus_wdata = 32'h3B;
    @(negedge clk);
    bus_wr = 1'b0;
    for (int n = 0; n < 400 && edge_n < 32; n++) @(negedge clk);
    wait_stat(3'b101);
    rd(A_RXD, r);
    chk(cap_words[0], 32'hC4, "R5 first word sent");
    chk(cap_words[1], 32'h3B, "R5 second word sent");
    chk(r, 32'hE7, "R5 latest word received");
    chk(32'(edge_n), 32, "R5 two words of edges");

    // R8 read held high across completion
    slv_reset(0, 0, 8);
    slv_words[0] = 32'h5A;
    wr(A_TXD, 32'h81);
    @(negedge clk);
    bus_addr = A_RXD; bus_rd = 1'b1;
    for (int n = 0; n < 400 && edge_n < 16; n++) @(negedge clk);
    @(negedge clk);
    bus_rd = 1'b0;
    peek(A_STAT, r); chk(32'(r[0]), 1, "R8 completion wins over read");
    rd(A_RXD, r); chk(r, 32'h5A, "R8 new word kept");
    peek(A_STAT, r); chk(32'(r[0]), 0, "R8 read clears flag");

    // R6 receive-only chaining
    wr(A_CFG, mk_cfg(0, 0, 0, 1, 8, 1, 0, 0, 0));
    slv_reset(0, 0, 8);
    slv_words[0] = 32'h96; slv_words[1] = 32'h4E; slv_words[2] = 32'hFF;
    wr(A_TXD, 32'h0);
    wait_stat(3'b101);
    repeat (20) @(negedge clk);
    chk(32'(edge_n), 16, "R6 no word before read");
    rd(A_RXD, r); chk(r, 32'h96, "R6 first word");
    wait_stat(3'b101);
    chk(32'(edge_n), 32, "R6 read launched next word");
    wr(A_CFG, mk_cfg(0, 0, 0, 1, 8, 0, 0, 0, 0));
    rd(A_RXD, r); chk(r, 32'h4E, "R6 second word");
    repeat (40) @(negedge clk);
    chk(32'(edge_n), 32, "R6 mode switch stops extra word");
    peek(A_STAT, r); chk(r, 32'h6, "R6 idle status");

    // R7 transmit-only
    wr(A_CFG, mk_cfg(1, 1, 1, 1, 8, 2, 0, 0, 0));
    slv_reset(1, 1, 8);
    slv_words[0] = 32'hAA;
    wr(A_TXD, 32'h6D);
    saw_gap = 1'b0;
    for (int n = 0; n < 1000; n++) begin
      peek(A_STAT, s);
      if (s[1] && !s[2]) saw_gap = 1'b1;
      if (s[1] && s[2]) break;
    end
    chk(32'(edge_n), 16, "R7 both flags only after last edge");
    chk(32'(saw_gap), 1, "R7 empty before idle");
    chk(32'(s[0]), 0, "R7 no received word");
    chk(cap_words[0], 32'h6D, "R7 word sent");

    // R11 DMA requests
    wr(A_CTRL, 32'h0);
    wr(A_CFG, mk_cfg(0, 0, 0, 1, 8, 0, 1, 1, 0));
    @(negedge clk);
    chk(32'(dma_tx_req), 1, "R11 tx request when empty");
    slv_reset(0, 0, 8);
    slv_words[0] = 32'h33;
    wr(A_TXD, 32'h44);
    chk(32'(dma_tx_req), 0, "R11 tx request drops on write");
    chk(32'(dma_rx_req), 0, "R11 rx request idle");
    wr(A_CTRL, 32'h1);
    wait_stat(3'b101);
    chk(32'(dma_rx_req), 1, "R11 rx request on word");
    chk(32'(dma_tx_req), 1, "R11 tx request after load");
    rd(A_RXD, r);
    @(negedge clk);
    chk(32'(dma_rx_req), 0, "R11 rx request cleared by read");
    wr(A_CFG, mk_cfg(0, 0, 0, 1, 8, 0, 0, 0, 0));
    slv_reset(0, 0, 8);
    wr(A_TXD, 32'h12);
    wait_stat(3'b101);
    chk(32'({dma_tx_req, dma_rx_req}), 0, "R11 requests masked by enables");

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule